// File: doc/BRIEF.md
# Low-Power State Sequencer with Bus Pin Control

This block decides, one clock at a time, whether a small controller core is running, idling or powered down. It also sets the external bus strobes and the two address/data port behaviours for each of those states. Software asks for idle or power-down. An enabled-interrupt flag can wake the core from idle. The chip's hardware reset input wakes it from either mode. While the core runs, the bus timing unit's own strobe and port-control levels pass straight through.

On entry to a low-power state the block records whether code was being fetched from external memory. That recorded flag, not the live input, then selects how the low-order bus (float or drive latch data) and the high-order port (address or latch data) behave until the core wakes. The block also provides three clock enables: one for the CPU, one for the DMA channels and one for the oscillator. It blocks the internal RAM write strobe whenever the core is not in normal operation, including the window in which a hardware reset is ending a low-power state.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low the block is in the running state. The four `run_*` inputs appear unchanged on `latch_strobe_o`, `fetch_strobe_o`, `lo_bus_float_o` and `hi_addr_sel_o`. All three clock enables are 1, and `ram_we_o` follows `ram_we_i`.
- R2: In the running state with `hw_reset` low, `req_idle` high and `req_pdown` low at a clock edge, the block enters idle. After that edge `cpu_clk_en_o` is 0, `dma_clk_en_o` is 0 and `osc_en_o` is 1.
- R3: In idle, `latch_strobe_o` and `fetch_strobe_o` are both 1.
- R4: In the running state with `hw_reset` low and `req_pdown` high at a clock edge, the block enters power-down. This applies whatever `req_idle` is. In power-down all three clock enables are 0 and both strobes are 0.
- R5: An `irq_pend` of 1 at a clock edge in idle, with `hw_reset` low, returns the block to the running state after that edge.
- R6: In power-down, `irq_pend` has no effect. The block stays in power-down until `hw_reset` is seen high.
- R7: A `hw_reset` of 1 at an edge in idle or power-down moves the block to a wake state. The wake state lasts while `hw_reset` stays high. In it both strobes are 1, `cpu_clk_en_o` is 1, `dma_clk_en_o` is 0, `osc_en_o` is 1, and both port controls are 0. The first edge with `hw_reset` low returns the block to the running state.
- R8: If `ext_code` was 1 on entry, `lo_bus_float_o` is 1 in idle and in power-down. `hi_addr_sel_o` is 1 in idle and 0 in power-down.
- R9: If `ext_code` was 0 on entry, `lo_bus_float_o` and `hi_addr_sel_o` are both 0 in idle and in power-down.
- R10: A change of `ext_code` while in idle or power-down has no effect on the port controls.
- R11: `ram_we_o` follows `ram_we_i` only in the running state. It is 0 in idle, in power-down and in the wake state.
- R12: `req_idle` and `req_pdown` are ignored in idle, in power-down and in the wake state. They are also ignored in the running state while `hw_reset` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's flops |
| req_idle | input | 1 | Software request to enter idle |
| req_pdown | input | 1 | Software request to enter power-down |
| irq_pend | input | 1 | An enabled interrupt is pending |
| hw_reset | input | 1 | Chip hardware reset input, active high |
| ext_code | input | 1 | Core is fetching code from external memory |
| run_latch | input | 1 | Address latch strobe from bus timing unit |
| run_fetch | input | 1 | Code read strobe from bus timing unit |
| run_lo_float | input | 1 | Low-order bus float request from bus timing unit |
| run_hi_addr | input | 1 | High-order port address select from bus timing unit |
| ram_we_i | input | 1 | Internal RAM write strobe from the CPU |
| latch_strobe_o | output | 1 | Address latch strobe pin level |
| fetch_strobe_o | output | 1 | Code read strobe pin level |
| lo_bus_float_o | output | 1 | 1: low-order bus floats; 0: drives |
| hi_addr_sel_o | output | 1 | 1: high-order port drives address; 0: latch data |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| dma_clk_en_o | output | 1 | DMA channel clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| ram_we_o | output | 1 | Gated internal RAM write strobe |

## Verification
The hardest condition to reach from the ports is a hardware reset that ends power-down while the CPU is still asserting a RAM write. To get there the stimulus first enters power-down with both requests high. It then raises `irq_pend` to show it is ignored, and changes `ext_code` to show it is not re-read. Next it raises `hw_reset` together with `ram_we_i` and holds both for several cycles, so the bench can check that the write stays blocked for the whole wake window. Only then does it release `hw_reset`, and it checks that the strobe passes again on the next cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_STOP = 2'd2,
        PM_WAKE = 2'd3
    } pm_state_e;

    typedef struct packed {
        pm_state_e st;
        logic      ext_mem;
    } pm_regs_t;

    typedef struct packed {
        logic latch;
        logic fetch;
        logic lo_float;
        logic hi_addr;
        logic cpu_en;
        logic dma_en;
        logic osc_en;
        logic ram_we;
    } pin_set_t;

    localparam pm_regs_t PM_REGS_RST = '{st: PM_RUN, ext_mem: 1'b0};

endpackage

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_idle,
    input  logic      req_pdown,
    input  logic      irq_pend,
    input  logic      hw_reset,
    input  logic      ext_code,
    output pm_state_e state_o,
    output logic      ext_mem_o
);

    pm_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.st)
            PM_RUN: begin
                if (!hw_reset) begin
                    if (req_pdown) begin
                        regs_d.st      = PM_STOP;
                        regs_d.ext_mem = ext_code;
                    end else if (req_idle) begin
                        regs_d.st      = PM_IDLE;
                        regs_d.ext_mem = ext_code;
                    end
                end
            end
            PM_IDLE: begin
                if (hw_reset)      regs_d.st = PM_WAKE;
                else if (irq_pend) regs_d.st = PM_RUN;
            end
            PM_STOP: begin
                if (hw_reset) regs_d.st = PM_WAKE;
            end
            PM_WAKE: begin
                if (!hw_reset) regs_d.st = PM_RUN;
            end
            default: regs_d.st = PM_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= PM_REGS_RST;
        else        regs_q <= regs_d;
    end

    assign state_o   = regs_q.st;
    assign ext_mem_o = regs_q.ext_mem;

    AST_IDLE_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n) (regs_q.st == PM_IDLE && irq_pend && !hw_reset) |=> (regs_q.st == PM_RUN)) else $error("idle irq wake"); // R5
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (regs_q.st == PM_STOP && !hw_reset) |=> (regs_q.st == PM_STOP)) else $error("stop left without reset"); // R6
    AST_RST_TO_WAKE: assert property (@(posedge clk) disable iff (!rst_n) ((regs_q.st == PM_IDLE || regs_q.st == PM_STOP) && hw_reset) |=> (regs_q.st == PM_WAKE)) else $error("reset wake"); // R7
    AST_WAKE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (regs_q.st == PM_WAKE && !hw_reset) |=> (regs_q.st == PM_RUN)) else $error("wake release"); // R7
    AST_EXT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (regs_q.st != PM_RUN) |=> $stable(regs_q.ext_mem)) else $error("ext flag moved"); // R10

endmodule

// File: rtl/pmc_pin_mux.sv
module pmc_pin_mux
    import pmc_pkg::*;
(
    input  pm_state_e state_i,
    input  logic      ext_mem_i,
    input  logic      run_latch,
    input  logic      run_fetch,
    input  logic      run_lo_float,
    input  logic      run_hi_addr,
    input  logic      ram_we_i,
    output pin_set_t  pins_o
);

    always_comb begin
        unique case (state_i)
            PM_IDLE: pins_o = '{latch: 1'b1, fetch: 1'b1, lo_float: ext_mem_i,
                                hi_addr: ext_mem_i, cpu_en: 1'b0, dma_en: 1'b0,
                                osc_en: 1'b1, ram_we: 1'b0};
            PM_STOP: pins_o = '{latch: 1'b0, fetch: 1'b0, lo_float: ext_mem_i,
                                hi_addr: 1'b0, cpu_en: 1'b0, dma_en: 1'b0,
                                osc_en: 1'b0, ram_we: 1'b0};
            PM_WAKE: pins_o = '{latch: 1'b1, fetch: 1'b1, lo_float: 1'b0,
                                hi_addr: 1'b0, cpu_en: 1'b1, dma_en: 1'b0,
                                osc_en: 1'b1, ram_we: 1'b0};
            default: pins_o = '{latch: run_latch, fetch: run_fetch,
                                lo_float: run_lo_float, hi_addr: run_hi_addr,
                                cpu_en: 1'b1, dma_en: 1'b1, osc_en: 1'b1,
                                ram_we: ram_we_i};
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_idle,
    input  logic req_pdown,
    input  logic irq_pend,
    input  logic hw_reset,
    input  logic ext_code,
    input  logic run_latch,
    input  logic run_fetch,
    input  logic run_lo_float,
    input  logic run_hi_addr,
    input  logic ram_we_i,
    output logic latch_strobe_o,
    output logic fetch_strobe_o,
    output logic lo_bus_float_o,
    output logic hi_addr_sel_o,
    output logic cpu_clk_en_o,
    output logic dma_clk_en_o,
    output logic osc_en_o,
    output logic ram_we_o
);

    pm_state_e state_w;
    logic      ext_mem_w;
    pin_set_t  pins_w;

    pmc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_idle  (req_idle),
        .req_pdown (req_pdown),
        .irq_pend  (irq_pend),
        .hw_reset  (hw_reset),
        .ext_code  (ext_code),
        .state_o   (state_w),
        .ext_mem_o (ext_mem_w)
    );

    pmc_pin_mux u_mux (
        .state_i      (state_w),
        .ext_mem_i    (ext_mem_w),
        .run_latch    (run_latch),
        .run_fetch    (run_fetch),
        .run_lo_float (run_lo_float),
        .run_hi_addr  (run_hi_addr),
        .ram_we_i     (ram_we_i),
        .pins_o       (pins_w)
    );

    assign latch_strobe_o = pins_w.latch;
    assign fetch_strobe_o = pins_w.fetch;
    assign lo_bus_float_o = pins_w.lo_float;
    assign hi_addr_sel_o  = pins_w.hi_addr;
    assign cpu_clk_en_o   = pins_w.cpu_en;
    assign dma_clk_en_o   = pins_w.dma_en;
    assign osc_en_o       = pins_w.osc_en;
    assign ram_we_o       = pins_w.ram_we;

    AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (!cpu_clk_en_o && osc_en_o) |-> (latch_strobe_o && fetch_strobe_o)) else $error("idle strobes"); // R3
    AST_STOP_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n) !osc_en_o |-> (!latch_strobe_o && !fetch_strobe_o && !cpu_clk_en_o && !dma_clk_en_o)) else $error("stop pins"); // R4
    AST_RAM_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n) ram_we_o |-> (ram_we_i && dma_clk_en_o && cpu_clk_en_o)) else $error("ram write leak"); // R11
    AST_REQ_IGNORED_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n) (!cpu_clk_en_o && osc_en_o && !hw_reset && !irq_pend) |=> (!cpu_clk_en_o && osc_en_o)) else $error("idle left by request"); // R12

endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_idle = 0, req_pdown = 0, irq_pend = 0, hw_reset = 0, ext_code = 0;
    logic run_latch = 0, run_fetch = 0, run_lo_float = 0, run_hi_addr = 0, ram_we_i = 0;
    logic latch_strobe_o, fetch_strobe_o, lo_bus_float_o, hi_addr_sel_o;
    logic cpu_clk_en_o, dma_clk_en_o, osc_en_o, ram_we_o;

    pwr_mode_ctrl dut (.*);

    always #5 clk = ~clk;

    typedef struct {
        int    due;
        int    mode;
        logic  ext;
        string tag;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;
    int   m_mode = 0;
    logic m_ext = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] expect_pins(int mode, logic ext);
        case (mode)
            1:       return {1'b1, 1'b1, ext, ext, 1'b0, 1'b0, 1'b1, 1'b0};
            2:       return {1'b0, 1'b0, ext, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
            3:       return {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
            default: return {run_latch, run_fetch, run_lo_float, run_hi_addr,
                             1'b1, 1'b1, 1'b1, ram_we_i};
        endcase
    endfunction

    // driver: applies one cycle of stimulus and queues the expected mode
    task automatic drive(input logic ri, input logic rp, input logic irq,
                         input logic hr, input logic ex, input logic we,
                         input string tag);
        int nxt;
        @(posedge clk);
        #1;
        req_idle = ri; req_pdown = rp; irq_pend = irq; hw_reset = hr;
        ext_code = ex; ram_we_i = we;
        run_latch = cyc[0]; run_fetch = cyc[1]; run_lo_float = cyc[2];
        run_hi_addr = ~cyc[0];
        nxt = m_mode;
        if (!rst_n) nxt = 0;
        else case (m_mode)
            0: if (!hr) begin
                   if (rp)      begin nxt = 2; m_ext = ex; end
                   else if (ri) begin nxt = 1; m_ext = ex; end
               end
            1: if (hr) nxt = 3; else if (irq) nxt = 1 - 1;
            2: if (hr) nxt = 3;
            default: if (!hr) nxt = 0;
        endcase
        m_mode = nxt;
        q.push_back('{due: cyc + 1, mode: nxt, ext: m_ext, tag: tag});
    endtask

    // monitor: compares the design against the queued expectation
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            logic [7:0] act, exp;
            it = q.pop_front();
            act = {latch_strobe_o, fetch_strobe_o, lo_bus_float_o, hi_addr_sel_o,
                   cpu_clk_en_o, dma_clk_en_o, osc_en_o, ram_we_o};
            exp = expect_pins(it.mode, it.ext);
            checks++;
            if (act !== exp) begin
                errors++;
                $display("FAIL %s cycle %0d actual=%b expected=%b", it.tag, cyc, act, exp);
            end
        end
    end

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state, pass-through and write strobe
        drive(0, 0, 0, 0, 0, 1, "R1");
        drive(1, 1, 0, 0, 1, 0, "R1");
        drive(0, 0, 0, 0, 0, 1, "R1");
        @(posedge clk); #1; rst_n = 1'b1;
        drive(0, 0, 0, 0, 0, 1, "R11");
        drive(0, 0, 0, 0, 0, 0, "R1");
        // R2 / R3 / R9: idle from internal code
        drive(1, 0, 0, 0, 0, 1, "R2");
        drive(0, 0, 0, 0, 0, 1, "R3");
        drive(0, 0, 0, 0, 1, 1, "R10");
        drive(1, 1, 0, 0, 1, 1, "R12");
        drive(0, 0, 0, 0, 0, 0, "R9");
        drive(0, 0, 1, 0, 0, 1, "R5");
        drive(0, 0, 0, 0, 0, 1, "R11");
        // R8: idle from external code
        drive(1, 0, 0, 0, 1, 0, "R8");
        drive(0, 0, 0, 0, 0, 0, "R8");
        drive(0, 0, 1, 0, 0, 0, "R5");
        // R4: power-down wins over idle, external code
        drive(1, 1, 0, 0, 1, 0, "R4");
        drive(0, 0, 0, 0, 1, 0, "R8");
        drive(0, 0, 1, 0, 0, 1, "R6");
        drive(0, 0, 1, 0, 0, 1, "R6");
        drive(1, 0, 0, 0, 0, 1, "R12");
        drive(0, 0, 0, 1, 0, 1, "R7");
        drive(0, 0, 1, 1, 0, 1, "R11");
        drive(1, 1, 0, 1, 0, 1, "R7");
        drive(0, 0, 0, 0, 0, 1, "R7");
        drive(0, 0, 0, 0, 0, 1, "R11");
        // R9: power-down from internal code
        drive(0, 1, 0, 0, 0, 0, "R9");
        drive(0, 0, 0, 0, 1, 0, "R10");
        drive(0, 0, 0, 1, 0, 0, "R7");
        drive(0, 0, 0, 0, 0, 0, "R7");
        // R12: requests ignored while hw_reset high in running state
        drive(1, 0, 0, 1, 0, 0, "R12");
        drive(0, 1, 0, 1, 0, 1, "R12");
        drive(0, 0, 0, 0, 0, 0, "R1");
        // R7: reset ends idle, write blocked
        drive(1, 0, 0, 0, 1, 0, "R2");
        drive(0, 0, 1, 1, 1, 1, "R7");
        drive(0, 0, 0, 1, 0, 1, "R11");
        drive(0, 0, 0, 0, 0, 1, "R7");
        drive(0, 0, 0, 0, 0, 0, "R1");
        repeat (3) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule